// File: doc/BRIEF.md
# Rate Selector and Interrupt Status Unit

This block is the timing and interrupt part of a real-time clock. A one-cycle enable at 32.768 kHz (`tick_32k`) advances a 15-stage binary divider. A 4-bit rate code picks one divider stage. That one selection drives both a square-wave output and a periodic event. A 3-bit oscillator field starts the divider, parks it at a preset, or freezes it. The divider produces an update-in-progress status and a transfer strobe once per second for the calendar logic outside the block. The first strobe comes half a second after the divider is started.

The unit also holds three interrupt flags: periodic (PF), alarm (AF) and update-ended (UF). It holds their enables and the square-wave enable, and it drives an active-low interrupt line. Alarm and update-done events come from outside as one-cycle pulses. A status read returns a snapshot and clears the flags when the read ends. Events that arrive while the read is active are kept and applied after it.

There are two state machines. The oscillator machine has states `OSC_OFF`, `OSC_HOLD` and `OSC_RUN`. From any state, field 010 goes to `OSC_RUN`: *start* when arriving from another state, which loads the preset, and *advance* when already running. Field 11X goes to `OSC_HOLD` (*park*). Every other field value goes to `OSC_OFF` (*stop*). The read machine has states `RD_IDLE` and `RD_HELD`. `RD_IDLE` goes to `RD_HELD` when `stat_rd` rises (*capture*). `RD_HELD` stays while `stat_rd` is high (*hold*) and goes back to `RD_IDLE` when it falls (*release*).

Top module: `rtc_rate_irq`

## Requirements
- R1: Rate codes map to square-wave frequencies as follows. Code 0 gives no output. Code 1 gives 256 Hz, code 2 gives 128 Hz and code 3 gives 8192 Hz. Codes 4 to 15 give 4096 Hz, halving at each step down to 2 Hz. When enabled, `sqw` equals the selected divider stage, with half-periods of 64, 128, 2 and 4·2^(code−4) ticks respectively. Code 0 holds `sqw` low.
- R2: While the square-wave enable is 0, `sqw` is low.
- R3: PF sets on every 0→1 transition of the selected stage caused by a tick, whether or not PIE is set. Code 0 never sets PF.
- R4: An `osc_ctl` value of 010 runs the divider. A value of 11X holds it at the preset 0x4000, where no selectable stage is high. Any other value freezes it at its current count.
- R5: After `osc_ctl` changes to 010 from another value, the edge that samples it loads the preset and does not count. With a tick on every later cycle, `upd_xfer` first pulses in the 16384th cycle after that edge, and then pulses every 32768 ticks.
- R6: `uip` is high during the last 8 counts before each transfer, while running. While `set_hold` is 1, `uip` is low and `upd_xfer` is suppressed.
- R7: `irq_n` is 0 exactly when (PF and PIE) or (AF and AIE) or (UF and UIE) holds.
- R8: While a read is active, `stat_rdata` = {IRQF, PF, AF, UF, 4'b0000}, captured at the cycle the read starts and held constant until it ends. Outside a read, `stat_rdata` is 0.
- R9: When a read ends, all flags are cleared. Any event seen from the read's first cycle through its last cycle, or in the ending cycle, is then set in the flags.
- R10: Reset clears PIE, AIE, UIE, the square-wave enable, all flags and any pending read. While `set_hold` is 1, UIE is cleared and cannot be written to 1.
- R11: An `alarm_ev` pulse sets AF and an `upd_done` pulse sets UF.
- R12: `en_wr` loads PIE, AIE, UIE and the square-wave enable from `en_pie`, `en_aie`, `en_uie` and `en_sqwe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | 32.768 kHz advance enable |
| osc_ctl | input | 3 | Oscillator field (010 run, 11X hold, else stop) |
| rate_sel | input | 4 | Rate code selecting the divider tap |
| set_hold | input | 1 | Freeze request; blocks transfer, clears UIE |
| en_wr | input | 1 | Enable-register write strobe |
| en_pie | input | 1 | Periodic interrupt enable write value |
| en_aie | input | 1 | Alarm interrupt enable write value |
| en_uie | input | 1 | Update-ended interrupt enable write value |
| en_sqwe | input | 1 | Square-wave enable write value |
| alarm_ev | input | 1 | Alarm match pulse |
| upd_done | input | 1 | Update-complete pulse |
| stat_rd | input | 1 | Status read cycle, high for its duration |
| stat_rdata | output | 8 | Status read data |
| sqw | output | 1 | Square-wave output |
| uip | output | 1 | Update-in-progress status |
| upd_xfer | output | 1 | One-second transfer strobe |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `stat_rd` is a level spanning the whole read cycle and drops for at least one clock between reads. They also assume that event inputs are single-cycle pulses that may arrive at any time, including at the edges of a read. The stimulus opens reads of one to four cycles only after a low cycle, fires alarm and update-done pulses at random, varies the tick density, changes the rate code and `set_hold` in the middle of a run, and steps the oscillator field through run, hold and stop values. Each period of the run follows a reset, so no property sees a divider or flag state that was not reached through the ports.

// File: rtl/rtc_rate_pkg.sv
`timescale 1ns/1ps
package rtc_rate_pkg;

    localparam int RATE_W = 4;
    localparam logic [2:0] OSC_FIELD_RUN = 3'b010;

    typedef enum logic [1:0] {
        OSC_OFF,
        OSC_HOLD,
        OSC_RUN
    } osc_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_HELD
    } rd_state_e;

    // divider stage driven by a nonzero rate code
    function automatic logic [3:0] tap_of(input logic [RATE_W-1:0] code);
        logic [3:0] idx;
        case (code)
            4'd1:    idx = 4'd6;
            4'd2:    idx = 4'd7;
            4'd3:    idx = 4'd1;
            default: idx = code - 4'd2;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/rtc_rate_div.sv
`timescale 1ns/1ps
module rtc_rate_div
    import rtc_rate_pkg::*;
#(
    parameter int STAGES   = 15,
    parameter int UIP_LEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [2:0]        osc_ctl,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              set_hold,
    input  logic              sqwe,
    output logic              sqw,
    output logic              per_ev,
    output logic              uip,
    output logic              upd_xfer
);

    localparam logic [STAGES-1:0] CNT_MAX   = '1;
    localparam logic [STAGES-1:0] PRESET    = {1'b1, {(STAGES-1){1'b0}}};
    localparam logic [STAGES-1:0] UIP_FLOOR = CNT_MAX - (STAGES)'(UIP_LEAD - 1);

    osc_state_e        st_q, st_d;
    logic [STAGES-1:0] cnt_q;
    logic [STAGES-1:0] rise;
    logic              field_run, field_hold, advancing, rate_on;
    logic [3:0]        tap_idx;

    assign field_run  = (osc_ctl == OSC_FIELD_RUN);
    assign field_hold = (osc_ctl[2:1] == 2'b11);

    // transitions: start/advance, park, stop
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OSC_OFF, OSC_HOLD, OSC_RUN: begin
                if (field_run)       st_d = OSC_RUN;
                else if (field_hold) st_d = OSC_HOLD;
                else                 st_d = OSC_OFF;
            end
            default: st_d = OSC_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= OSC_OFF;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= PRESET;
        end else begin
            unique case (st_d)
                OSC_HOLD: cnt_q <= PRESET;
                OSC_RUN: begin
                    if (st_q != OSC_RUN) cnt_q <= PRESET;
                    else if (tick)       cnt_q <= cnt_q + 1'b1;
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // rising transition of each stage on the next advance
    for (genvar k = 0; k < STAGES; k++) begin : g_rise
        if (k == 0) begin : g_lsb
            assign rise[k] = ~cnt_q[0];
        end else begin : g_upper
            assign rise[k] = ~cnt_q[k] & (&cnt_q[k-1:0]);
        end
    end

    assign advancing = tick && (st_q == OSC_RUN) && field_run;
    assign rate_on   = (rate_sel != '0);
    assign tap_idx   = tap_of(rate_sel);

    assign per_ev   = advancing && rate_on && rise[tap_idx];
    assign sqw      = sqwe && rate_on && cnt_q[tap_idx];
    assign uip      = (st_q == OSC_RUN) && !set_hold && (cnt_q >= UIP_FLOOR);
    assign upd_xfer = advancing && (cnt_q == CNT_MAX) && !set_hold;

    // R5
    xfer_in_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_xfer |-> uip);

    // R4
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_d == OSC_OFF) |=> $stable(cnt_q));

    // R4
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OSC_HOLD) |-> !sqw);

endmodule

// File: rtl/rtc_irq_stat.sv
`timescale 1ns/1ps
module rtc_irq_stat
    import rtc_rate_pkg::*;
#(
    parameter int NSRC   = 3,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_hold,
    input  logic              en_wr,
    input  logic              en_pie,
    input  logic              en_aie,
    input  logic              en_uie,
    input  logic              en_sqwe,
    input  logic              per_ev,
    input  logic              alarm_ev,
    input  logic              upd_done,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_rdata,
    output logic              irq_n,
    output logic              sqwe
);

    localparam int PAD_W = STAT_W - NSRC - 1;

    rd_state_e       rd_q, rd_d;
    logic [NSRC-1:0] flag_q, pend_q, ena_q, ev;
    logic [NSRC:0]   snap_q;
    logic            sqwe_q, irqf;

    // bit order {periodic, alarm, update-ended}
    assign ev   = {per_ev, alarm_ev, upd_done};
    assign irqf = |(flag_q & ena_q);

    // transitions: capture, hold, release
    always_comb begin
        rd_d = rd_q;
        unique case (rd_q)
            RD_IDLE: rd_d = stat_rd ? RD_HELD : RD_IDLE;
            RD_HELD: rd_d = stat_rd ? RD_HELD : RD_IDLE;
            default: rd_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= RD_IDLE;
        else        rd_q <= rd_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
            pend_q <= '0;
            snap_q <= '0;
        end else begin
            unique case (rd_q)
                RD_IDLE: begin
                    if (stat_rd) begin
                        snap_q <= {irqf, flag_q};
                        pend_q <= ev;
                    end else begin
                        flag_q <= flag_q | ev;
                    end
                end
                RD_HELD: begin
                    if (stat_rd) begin
                        pend_q <= pend_q | ev;
                    end else begin
                        flag_q <= pend_q | ev;
                        pend_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q  <= '0;
            sqwe_q <= 1'b0;
        end else begin
            if (en_wr) begin
                ena_q  <= {en_pie, en_aie, en_uie};
                sqwe_q <= en_sqwe;
            end
            if (set_hold) ena_q[0] <= 1'b0;
        end
    end

    assign stat_rdata = (rd_q == RD_HELD) ? {snap_q, {PAD_W{1'b0}}} : '0;
    assign irq_n      = ~irqf;
    assign sqwe       = sqwe_q;

    // R8
    snap_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q == RD_HELD && stat_rd) |=> $stable(stat_rdata));

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q == RD_HELD && !stat_rd && ev == '0 && pend_q == '0) |=> irq_n);

    // R10
    uie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_hold |=> !ena_q[0]);

    // R3
    pf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_ev && rd_q == RD_IDLE && !stat_rd) |=> flag_q[NSRC-1]);

endmodule

// File: rtl/rtc_rate_irq.sv
`timescale 1ns/1ps
module rtc_rate_irq
    import rtc_rate_pkg::*;
#(
    parameter int STAGES   = 15,
    parameter int UIP_LEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [2:0]        osc_ctl,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              set_hold,
    input  logic              en_wr,
    input  logic              en_pie,
    input  logic              en_aie,
    input  logic              en_uie,
    input  logic              en_sqwe,
    input  logic              alarm_ev,
    input  logic              upd_done,
    input  logic              stat_rd,
    output logic [7:0]        stat_rdata,
    output logic              sqw,
    output logic              uip,
    output logic              upd_xfer,
    output logic              irq_n
);

    logic per_ev;
    logic sqwe;

    rtc_rate_div #(
        .STAGES   (STAGES),
        .UIP_LEAD (UIP_LEAD)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_32k),
        .osc_ctl  (osc_ctl),
        .rate_sel (rate_sel),
        .set_hold (set_hold),
        .sqwe     (sqwe),
        .sqw      (sqw),
        .per_ev   (per_ev),
        .uip      (uip),
        .upd_xfer (upd_xfer)
    );

    rtc_irq_stat #(
        .NSRC   (3),
        .STAT_W (8)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_hold   (set_hold),
        .en_wr      (en_wr),
        .en_pie     (en_pie),
        .en_aie     (en_aie),
        .en_uie     (en_uie),
        .en_sqwe    (en_sqwe),
        .per_ev     (per_ev),
        .alarm_ev   (alarm_ev),
        .upd_done   (upd_done),
        .stat_rd    (stat_rd),
        .stat_rdata (stat_rdata),
        .irq_n      (irq_n),
        .sqwe       (sqwe)
    );

endmodule

// File: tb/rtc_rate_irq_bench.sv
`timescale 1ns/1ps
module rtc_rate_irq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [2:0] osc_ctl = 3'b000;
    logic [3:0] rate_sel = 4'd0;
    logic       set_hold = 1'b0;
    logic       en_wr = 1'b0, en_pie = 1'b0, en_aie = 1'b0, en_uie = 1'b0, en_sqwe = 1'b0;
    logic       alarm_ev = 1'b0, upd_done = 1'b0, stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       sqw, uip, upd_xfer, irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    int rd_left = 0;
    bit started = 0;
    bit done = 0;

    // behavioural reference state
    int       m_st = 0;          // 0 stopped, 1 parked, 2 running
    int       m_cnt = 16384;
    bit [2:0] m_flag = '0, m_pend = '0, m_en = '0;
    bit [3:0] m_snap = '0;
    bit       m_rd = 0, m_sqwe = 0;

    always #2.5 clk = ~clk;

    rtc_rate_irq u_rtc_rate_irq (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .osc_ctl(osc_ctl),
        .rate_sel(rate_sel), .set_hold(set_hold), .en_wr(en_wr), .en_pie(en_pie),
        .en_aie(en_aie), .en_uie(en_uie), .en_sqwe(en_sqwe), .alarm_ev(alarm_ev),
        .upd_done(upd_done), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .sqw(sqw), .uip(uip), .upd_xfer(upd_xfer), .irq_n(irq_n)
    );

    // half-period in ticks, from the frequency named in R1
    function automatic int half_of(logic [3:0] c);
        int f;
        if (c == 0) return 1;
        case (c)
            4'd1:    f = 256;
            4'd2:    f = 128;
            4'd3:    f = 8192;
            default: f = 4096 >> (int'(c) - 4);
        endcase
        return 16384 / f;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        bit frun, fhold, adv, pev, irqf;
        bit [2:0] ev;
        int h;
        started = 1;
        frun  = (osc_ctl == 3'b010);
        fhold = (osc_ctl[2:1] == 2'b11);
        adv   = tick_32k && m_st == 2 && frun;
        h     = half_of(rate_sel);
        pev   = adv && rate_sel != 0 && ((m_cnt + 1) % (2 * h) == h);
        ev    = {pev, alarm_ev, upd_done};
        irqf  = |(m_flag & m_en);
        if (!rst_n) begin
            m_st = 0; m_cnt = 16384; m_flag = 0; m_pend = 0; m_snap = 0;
            m_rd = 0; m_en = 0; m_sqwe = 0;
        end else begin
            if (frun) begin
                if (m_st != 2) begin m_cnt = 16384; m_st = 2; end
                else if (tick_32k) m_cnt = (m_cnt + 1) % 32768;
            end else if (fhold) begin
                m_st = 1; m_cnt = 16384;
            end else begin
                m_st = 0;
            end
            if (en_wr) begin m_en = {en_pie, en_aie, en_uie}; m_sqwe = en_sqwe; end
            if (set_hold) m_en[0] = 1'b0;
            if (!m_rd) begin
                if (stat_rd) begin m_snap = {irqf, m_flag}; m_pend = ev; m_rd = 1; end
                else m_flag = m_flag | ev;
            end else begin
                if (stat_rd) m_pend = m_pend | ev;
                else begin m_flag = m_pend | ev; m_pend = 0; m_rd = 0; end
            end
        end
    end

    always @(negedge clk) begin
        bit e_sqw, e_uip, e_xfer, e_irq_n;
        int h;
        if (started && !done) begin
            h       = half_of(rate_sel);
            e_sqw   = m_sqwe && rate_sel != 0 && ((m_cnt / h) % 2 == 1);
            e_uip   = m_st == 2 && !set_hold && m_cnt >= 32760;
            e_xfer  = tick_32k && m_st == 2 && osc_ctl == 3'b010 && m_cnt == 32767 && !set_hold;
            e_irq_n = !(|(m_flag & m_en));
            chk("R1/R2/R4 sqw", {7'd0, sqw}, {7'd0, e_sqw});
            chk("R6 uip", {7'd0, uip}, {7'd0, e_uip});
            chk("R5/R6 upd_xfer", {7'd0, upd_xfer}, {7'd0, e_xfer});
            chk("R3/R7/R11/R12 irq_n", {7'd0, irq_n}, {7'd0, e_irq_n});
            chk("R8/R9 stat_rdata", stat_rdata, m_rd ? {m_snap, 4'b0} : 8'h00);
        end
    end

    task automatic drive_rand(int tick_pct);
        @(posedge clk); #1;
        tick_32k = ($urandom_range(99) < tick_pct);
        alarm_ev = ($urandom_range(199) == 0);
        upd_done = ($urandom_range(249) == 0);
        en_wr    = ($urandom_range(299) == 0);
        en_pie   = 1'($urandom_range(1));
        en_aie   = 1'($urandom_range(1));
        en_uie   = 1'($urandom_range(1));
        en_sqwe  = ($urandom_range(3) != 0);
        if (rd_left > 0) begin
            stat_rd = 1'b1; rd_left--;
        end else if (stat_rd) begin
            stat_rd = 1'b0;
        end else if ($urandom_range(119) == 0) begin
            stat_rd = 1'b1; rd_left = $urandom_range(3);
        end
    endtask

    task automatic quiet_inputs();
        alarm_ev = 0; upd_done = 0; en_wr = 0; stat_rd = 0; rd_left = 0;
    endtask

    // R5: count cycles from the field write to the first transfer strobe
    task automatic first_xfer_check();
        int  n = 0;
        bit  seen = 0;
        @(posedge clk); #1;
        quiet_inputs();
        set_hold = 0; tick_32k = 1; osc_ctl = 3'b010;
        while (!seen && n < 20000) begin
            @(negedge clk);
            n++;
            if (upd_xfer) seen = 1;
        end
        // one write cycle, then 16384 cycles after the sampling edge
        chk("R5 first transfer delay", 8'(n >> 8), 8'(16385 >> 8));
        chk("R5 first transfer delay low", 8'(n), 8'(16385));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset irq_n", {7'd0, irq_n}, 8'd1);
        chk("R10 reset stat_rdata", stat_rdata, 8'h00);
        chk("R2 reset sqw", {7'd0, sqw}, 8'd0);

        repeat (200) drive_rand(80);

        @(posedge clk); #1;
        quiet_inputs();
        en_wr = 1; en_sqwe = 1; en_pie = 1; rate_sel = 4'd3;
        first_xfer_check();

        for (int c = 0; c < 16; c++) begin
            @(posedge clk); #1 rate_sel = 4'(c);
            repeat (800) drive_rand(100);
        end

        for (int i = 0; i < 70000; i++) begin
            if (i % 6000 == 0) begin @(posedge clk); #1 set_hold = ~set_hold; end
            if (i % 3000 == 0) begin @(posedge clk); #1 rate_sel = 4'($urandom_range(15)); end
            drive_rand(75);
        end

        @(posedge clk); #1 set_hold = 0; osc_ctl = 3'b110;
        repeat (500) drive_rand(90);
        @(posedge clk); #1 osc_ctl = 3'b101;
        repeat (500) drive_rand(90);
        @(posedge clk); #1 osc_ctl = 3'b111;
        repeat (300) drive_rand(90);
        @(posedge clk); #1 osc_ctl = 3'b000;
        repeat (100) drive_rand(90);
        first_xfer_check();

        repeat (150) drive_rand(100);
        @(posedge clk); #1 rst_n = 1'b0; quiet_inputs();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R10 mid-run reset irq_n", {7'd0, irq_n}, 8'd1);
        chk("R10 mid-run reset sqw", {7'd0, sqw}, 8'd0);
        repeat (150) drive_rand(100);

        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule